// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

When the watchdog expires, this block drives a reset pulse onto an external pin. The pulse length is set in microseconds by a 32-bit configuration register. The register's low bits hold a duration field. A field value of N gives a pulse of N+1 ticks of a 1 MHz tick-enable input. A value of zero therefore still gives the shortest pulse of one tick.

Software cannot write the pin's polarity and drive mode directly. Each one changes only when the top byte of a register write carries one of four key values. Any other top byte leaves both settings as they were, but the duration field still takes the written value. On read, bits 31 and 30 show the two settings.

The pin interface is a data output and an output enable. In push-pull mode the pin is always driven. In open-drain mode the pin is driven only while the pulse is active; at all other times it is released.

Top module: `wdog_ext_pulse`

## Requirements
- R1: After reset the duration field is 0xFF, the output is active-low and open-drain, the pulse is inactive, and the register reads 0x000000FF. The pins show `pin_oe`=0 and `pin_out`=1.
- R2: A write loads the low DUR_W bits of the write data into the duration field, effective from the next cycle. Bits 29 down to DUR_W always read as zero.
- R3: A write whose bits 31:24 equal 0xA5 sets active-high polarity, and read bit 31 then shows 1. A write whose bits 31:24 equal 0x5A sets active-low polarity, and bit 31 then shows 0.
- R4: A write whose bits 31:24 equal 0xA8 selects push-pull drive, and read bit 30 then shows 1. A write whose bits 31:24 equal 0x8A selects open-drain drive, and bit 30 then shows 0.
- R5: A write whose top byte is none of the four keys leaves read bits 31:30 unchanged, while the duration field is still updated.
- R6: A `trigger` in a cycle with no pulse active starts the pulse in the next cycle. With N the duration field value at the trigger, the pulse ends in the cycle after the (N+1)-th `tick_1us` seen while it is active. A tick present in the trigger cycle is not counted.
- R7: A `trigger` that arrives while a pulse is active is ignored: the pulse neither restarts nor gets longer, and no second pulse follows.
- R8: The duration is captured when the pulse starts. A register write during a pulse changes only later pulses.
- R9: The pin follows the current mode. `pin_out` equals the active level while the pulse is active and the inactive level otherwise. In push-pull mode `pin_oe` is always 1. In open-drain mode `pin_oe` is 1 only while the pulse is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value: polarity, drive mode, duration |
| tick_1us | input | 1 | One-cycle strobe at 1 MHz |
| trigger | input | 1 | Watchdog expiry event |
| pin_out | output | 1 | Pin data level |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench builds the block with DUR_W=20, the wider field variant. This lets a single write place a non-zero value above bit 19, so the test can show that bits 29:20 read as zero while a 20-bit duration is kept. Pulses use short programmed durations and the 0xFF reset default, so the bench also reaches the one-tick minimum pulse and the full default length. The bench drives the tick strobe every third clock, which makes it possible to tell a pulse that ends on the tick from one that ends a clock early or late.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
  localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

  typedef struct packed {
    logic pol_high;   // 1: asserted level is high
    logic push_pull;  // 1: pin always driven
  } wdp_mode_t;

  typedef enum logic [2:0] {
    KEY_NONE,
    KEY_SET_HIGH,
    KEY_SET_LOW,
    KEY_SET_PP,
    KEY_SET_OD
  } wdp_key_e;

  localparam wdp_mode_t MODE_RESET = '{pol_high: 1'b0, push_pull: 1'b0};

  // Classify the top byte of a register write.
  function automatic wdp_key_e decode_key(input logic [7:0] top);
    wdp_key_e k;
    case (top)
      KEY_POL_HIGH: k = KEY_SET_HIGH;
      KEY_POL_LOW:  k = KEY_SET_LOW;
      KEY_DRV_PP:   k = KEY_SET_PP;
      KEY_DRV_OD:   k = KEY_SET_OD;
      default:      k = KEY_NONE;
    endcase
    return k;
  endfunction

  // New mode after applying a decoded key to the present one.
  function automatic wdp_mode_t apply_key(input wdp_mode_t cur, input wdp_key_e k);
    wdp_mode_t nxt;
    nxt = cur;
    case (k)
      KEY_SET_HIGH: nxt.pol_high  = 1'b1;
      KEY_SET_LOW:  nxt.pol_high  = 1'b0;
      KEY_SET_PP:   nxt.push_pull = 1'b1;
      KEY_SET_OD:   nxt.push_pull = 1'b0;
      default:      nxt = cur;
    endcase
    return nxt;
  endfunction

  // Electrical level of the pin for a given assertion state.
  function automatic logic level_of(input logic pol_high, input logic asserted);
    return asserted ? pol_high : ~pol_high;
  endfunction

  // Enable: push-pull always drives, open-drain drives only when asserted.
  function automatic logic enable_of(input logic push_pull, input logic asserted);
    return push_pull | asserted;
  endfunction

endpackage

// File: rtl/wdp_cfg_reg.sv
module wdp_cfg_reg
  import wdp_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [31:0]      wdata,
  output logic [DUR_W-1:0] dur_q,
  output wdp_mode_t        mode_q,
  output logic [31:0]      rdata
);

  localparam int                RSV_W   = 30 - DUR_W;
  localparam logic [DUR_W-1:0]  DUR_RST = DUR_W'(8'hFF);

  wdp_key_e  key;
  wdp_mode_t mode_d;

  assign key    = decode_key(wdata[31:24]);
  assign mode_d = apply_key(mode_q, key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q  <= DUR_RST;
      mode_q <= MODE_RESET;
    end else if (wr) begin
      dur_q  <= wdata[DUR_W-1:0];
      mode_q <= mode_d;
    end
  end

  wire unused_wdata_mid = ^wdata[23:DUR_W];

  assign rdata = {mode_q.pol_high, mode_q.push_pull, {RSV_W{1'b0}}, dur_q};

endmodule

// File: rtl/wdp_pulse_timer.sv
module wdp_pulse_timer #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trigger,
  input  logic [DUR_W-1:0] dur_in,
  output logic             pulse_on,
  output logic             ev_start,
  output logic             ev_end
);

  logic [DUR_W-1:0] remain;

  assign ev_start = trigger & ~pulse_on;
  assign ev_end   = pulse_on & tick & (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_on <= 1'b0;
      remain   <= '0;
    end else if (ev_start) begin
      pulse_on <= 1'b1;
      remain   <= dur_in;
    end else if (ev_end) begin
      pulse_on <= 1'b0;
    end else if (pulse_on && tick) begin
      remain   <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/wdp_pad_drive.sv
module wdp_pad_drive
  import wdp_pkg::*;
(
  input  wdp_mode_t mode,
  input  logic      asserted,
  output logic      pad_o,
  output logic      pad_oe
);

  assign pad_o  = level_of(mode.pol_high, asserted);
  assign pad_oe = enable_of(mode.push_pull, asserted);

endmodule

// File: rtl/wdog_ext_pulse.sv
module wdog_ext_pulse
  import wdp_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tick_1us,
  input  logic        trigger,
  output logic        pin_out,
  output logic        pin_oe
);

  logic [DUR_W-1:0] dur_q;
  wdp_mode_t        mode_q;
  logic             pulse_on;
  logic             ev_start;
  logic             ev_end;

  wdp_cfg_reg #(.DUR_W(DUR_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .dur_q  (dur_q),
    .mode_q (mode_q),
    .rdata  (reg_rdata)
  );

  wdp_pulse_timer #(.DUR_W(DUR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_1us),
    .trigger  (trigger),
    .dur_in   (dur_q),
    .pulse_on (pulse_on),
    .ev_start (ev_start),
    .ev_end   (ev_end)
  );

  wdp_pad_drive u_pad (
    .mode     (mode_q),
    .asserted (pulse_on),
    .pad_o    (pin_out),
    .pad_oe   (pin_oe)
  );

endmodule

// File: rtl/wdog_ext_pulse_chk.sv
module wdog_ext_pulse_chk #(
  parameter int DUR_W = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        tick_1us,
  input logic        trigger,
  input logic        pin_out,
  input logic        pin_oe,
  input logic        pulse_on,
  input logic        ev_start,
  input logic        ev_end
);

  logic [DUR_W:0] ticks_seen;
  logic [DUR_W:0] target;
  logic           plain_top;

  assign plain_top = (reg_wdata[31:24] != 8'hA5) && (reg_wdata[31:24] != 8'h5A) &&
                     (reg_wdata[31:24] != 8'hA8) && (reg_wdata[31:24] != 8'h8A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks_seen <= '0;
      target     <= '0;
    end else if (ev_start) begin
      ticks_seen <= '0;
      target     <= {1'b0, reg_rdata[DUR_W-1:0]};
    end else if (pulse_on && tick_1us) begin
      ticks_seen <= ticks_seen + 1'b1;
    end
  end

  wire unused_mid = ^reg_wdata[23:DUR_W] ^ ^reg_rdata[29:DUR_W];

  AST_WRITE_DUR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[DUR_W-1:0] == $past(reg_wdata[DUR_W-1:0])); // R2
  AST_POL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[31:24] == 8'hA5 |=> reg_rdata[31]); // R3
  AST_POL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[31:24] == 8'h5A |=> !reg_rdata[31]); // R3
  AST_DRV_PP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[31:24] == 8'hA8 |=> reg_rdata[30]); // R4
  AST_DRV_OD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[31:24] == 8'h8A |=> !reg_rdata[30]); // R4
  AST_KEEP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && plain_top |=> $stable(reg_rdata[31:30])); // R5
  AST_START: assert property (@(posedge clk) disable iff (!rst_n)
    trigger && !pulse_on |=> pulse_on); // R6
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |-> ticks_seen == target); // R6 R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on |-> ticks_seen <= target); // R8
  AST_IGNORE_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_on && trigger && !ev_end |=> pulse_on && $stable(target)); // R7
  AST_OE_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[30] && !pulse_on |-> !pin_oe); // R9
  AST_OE_PUSH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[30] |-> pin_oe); // R9
  AST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out == (pulse_on ? reg_rdata[31] : !reg_rdata[31])); // R9

endmodule

bind wdog_ext_pulse wdog_ext_pulse_chk #(.DUR_W(DUR_W)) u_chk (.*);

// File: tb/tb_wdog_ext_pulse.sv
`timescale 1ns/1ps
module tb_wdog_ext_pulse;

  localparam int DUR_W    = 20;
  localparam int TICK_DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_1us = 1'b0;
  logic        trigger = 1'b0;
  logic        pin_out;
  logic        pin_oe;

  wdog_ext_pulse #(.DUR_W(DUR_W)) dut (.*);

  always #2 clk = ~clk;

  typedef struct { int len; string req; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  bit mon_on = 0;
  bit finished = 0;

  // Reference model of the register.
  int unsigned exp_dur = 32'hFF;
  bit exp_pol = 0;
  bit exp_pp  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] exp_rdata();
    return {exp_pol, exp_pp, 10'b0, exp_dur[DUR_W-1:0]};
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic reg_write(input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(posedge clk);
    exp_dur = v & ((1 << DUR_W) - 1);
    if (v[31:24] == 8'hA5) exp_pol = 1;
    else if (v[31:24] == 8'h5A) exp_pol = 0;
    else if (v[31:24] == 8'hA8) exp_pp = 1;
    else if (v[31:24] == 8'h8A) exp_pp = 0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic check_read(input string req);
    check(reg_rdata === exp_rdata(), req, "readback", reg_rdata, exp_rdata());
  endtask

  task automatic check_idle_pins(input string req);
    check(pin_oe === exp_pp, req, "idle pin_oe", pin_oe, exp_pp);
    check(pin_out === !exp_pol, req, "idle pin_out", pin_out, !exp_pol);
  endtask

  // Drive one trigger. When expect_start is set, a pulse of the current
  // model duration is queued and the start cycle and active pins are checked.
  task automatic fire(input bit expect_start, input string req, input bit wait_end);
    int target;
    target = done_cnt + 1;
    @(negedge clk);
    trigger = 1'b1;
    if (expect_start) exp_q.push_back('{len: int'(exp_dur) + 1, req: req});
    @(posedge clk);
    #1;
    if (expect_start) begin
      check(pin_oe === 1'b1, "R9", "active pin_oe", pin_oe, 1);
      check(pin_out === exp_pol, "R6", "pin at start cycle", pin_out, exp_pol);
    end
    @(negedge clk);
    trigger = 1'b0;
    if (wait_end) wait (done_cnt >= target);
  endtask

  // Tick generator: one-cycle strobe every TICK_DIV clocks.
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tick_1us = (tc == TICK_DIV - 1);
      tc = (tc + 1) % TICK_DIV;
    end
  end

  // Monitor: measures each pulse in ticks and compares with the scoreboard.
  initial begin
    int ticks = 0;
    bit was = 0;
    bit now_on;
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        now_on = pin_oe && (pin_out == exp_pol);
        if (was && tick_1us) ticks++;
        if (was && !now_on) begin
          if (exp_q.size() == 0) begin
            check(0, "R7", "unexpected pulse length", ticks, 0);
          end else begin
            e = exp_q.pop_front();
            check(ticks == e.len, e.req, "pulse ticks", ticks, e.len);
          end
          ticks = 0;
          done_cnt++;
        end
        was = now_on;
      end
    end
  end

  initial begin
    #(4 * 200000);
    check(0, "R6", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reg_rdata === 32'h0000_00FF, "R1", "reset readback", reg_rdata, 32'hFF);
    check(pin_oe === 1'b0, "R1", "reset pin_oe", pin_oe, 0);
    check(pin_out === 1'b1, "R1", "reset pin_out", pin_out, 1);
    mon_on = 1;

    fire(1, "R1", 1);                    // default 0xFF -> 256 ticks

    reg_write(32'h3FF0_0003);            // R2: bits 29:20 read zero; R5: mode kept
    check_read("R2");
    check(reg_rdata[31:30] === 2'b00, "R5", "mode after plain top byte", reg_rdata[31:30], 0);
    fire(1, "R6", 1);

    reg_write(32'hA500_0000);            // R3 active-high, duration 0
    check_read("R3");
    check_idle_pins("R9");
    fire(1, "R6", 1);                    // minimum one-tick pulse

    reg_write(32'hA800_0005);            // R4 push-pull
    check_read("R4");
    check_idle_pins("R9");
    fire(1, "R9", 1);

    reg_write(32'h1200_0007);            // R5 non-key top byte
    check_read("R5");

    reg_write(32'h5A00_0009);            // R3 active-low
    check_read("R3");
    check_idle_pins("R9");

    fire(1, "R8", 0);                    // 10 ticks, not waited
    reg_write(32'h0000_0002);            // R8 mid-pulse write
    check_read("R8");
    fire(0, "R7", 0);                    // R7 ignored re-trigger
    wait (exp_q.size() == 0);
    repeat (4 * TICK_DIV) @(negedge clk);
    check_idle_pins("R7");

    fire(1, "R8", 1);                    // new duration 2 -> 3 ticks

    reg_write(32'h8A00_0000);            // R4 open-drain
    check_read("R4");
    check_idle_pins("R9");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7", "scoreboard empty", exp_q.size(), 0);
    check(done_cnt == 6, "R7", "pulse count", done_cnt, 6);
    report();
  end

endmodule